// File: doc/BRIEF.md
# ECC Engine Control and Interrupt Register File

This block is the software-visible front of a page-oriented error-correction data engine. A processor reaches it through a plain 32-bit register port made of address, write data, write enable, read enable and read data. Through that port it sets the engine configuration: an enable bit and a correction-type index. It also sets the host transfer mode, the chunk count, the slave window address and the main and spare DMA addresses. The block drives all of these to the datapath as levels.

Six hardware event inputs feed an interrupt status register through two masks. The status-enable mask decides whether an event is recorded at all. The signal-enable mask decides whether a recorded bit drives the interrupt line. Software clears recorded bits by writing ones to them.

A write to the DMA control register with its go bit set sends a single-cycle start pulse to the datapath, together with a direction level. The spare-layout register is read-only. Its metadata, parity, reserved and total byte counts are derived from the correction type that is currently configured.

Top module: `ecc_regfile`

## Requirements
- R1: After reset every writable register, the status register, the interrupt output and the start pulse are 0, and so are the configuration and DMA control read-backs.
- R2: A read returns its data on rdata_o one cycle after the read-enable cycle. Writable registers read back through fixed masks: configuration 0x79 (bit0 enable, bits [6:3] type), host mode 0x35, chunk count in its low 8 bits, and the slave, main and spare addresses in all 32 bits.
- R3: Status bits are mapped as follows: bit0 transfer done, bit1 main DMA, bit2 spare DMA, bit3 ECC error, bit4 to-spare, bit5 to-main. A high event input sets its status bit at the next clock edge only when the matching status-enable bit (offset 0x08) is 1. Otherwise the event is dropped.
- R4: Writing to status (offset 0x04) clears each bit written as 1 and leaves each bit written as 0 unchanged. If an enabled event arrives for a bit in the same cycle that the bit is cleared, the bit is set.
- R5: irq_o is high exactly when some status bit and the same bit of signal-enable (offset 0x0C) are both 1. It follows the registered values with no added delay.
- R6: A write to DMA control (offset 0x40) with bit31 set raises start_o for exactly the one cycle after the write. Bit31 always reads 0. Bits 1, 29 and 30 are kept and read back, and dir_read_o equals bit1.
- R7: Spare layout (offset 0x28) packs the metadata size in [7:0], parity in [15:8], reserved in [23:16] and total in [31:24]. The correction strengths are 4, 8, 40 and 48 for types 0, 1, 2 and 3, and any type above 3 uses 48. Parity is ceil(strength*GF_BITS/8) bytes. The total is 32 for the two lower strengths and 96 for the two upper ones. Reserved is whatever remains after metadata and parity. Writes to this register have no effect.
- R8: Chunk size (offset 0x20) reads STEP_BYTES plus the total spare size, and main size (offset 0x24) reads STEP_BYTES. Both ignore writes. Unmapped offsets read 0 and ignore writes.
- R9: engine_en_o, ecc_type_o, host_mode_o, chunk_cnt_o and the three address outputs carry the stored register values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| evt_i | input | 6 | Hardware event inputs, one per status bit |
| irq_o | output | 1 | Interrupt request |
| engine_en_o | output | 1 | Engine enable |
| ecc_type_o | output | 4 | Correction-type index |
| host_mode_o | output | 6 | Host transfer mode bits |
| chunk_cnt_o | output | CNT_W | Chunks per transfer |
| slave_addr_o | output | 32 | Slave window address |
| main_addr_o | output | 32 | Main data DMA address |
| spare_addr_o | output | 32 | Spare data DMA address |
| start_o | output | 1 | One-cycle transfer launch pulse |
| dir_read_o | output | 1 | 1 when the transfer reads from NAND |

## Verification
The assertions check on every cycle that a status bit rises only after an enabled event and falls only after a write-one-to-clear, that the start pulse lasts exactly one cycle and always follows a DMA control write with the go bit, that the go bit never reads back as 1, and that the spare-layout fields add up to the total. Only the bench scenarios can show the rest. These are the exact read-back masks, the spare values for each correction type including the clamp above type 3, an event winning over a clear in the same cycle, the interrupt following changes in signal-enable, and the silence of unmapped and read-only offsets.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

  localparam int unsigned EVT_N = 6;

  localparam logic [7:0] OFS_CFG       = 8'h00;
  localparam logic [7:0] OFS_STS       = 8'h04;
  localparam logic [7:0] OFS_STS_EN    = 8'h08;
  localparam logic [7:0] OFS_SIG_EN    = 8'h0C;
  localparam logic [7:0] OFS_HOST      = 8'h10;
  localparam logic [7:0] OFS_SLAVE     = 8'h14;
  localparam logic [7:0] OFS_CHUNK_SZ  = 8'h20;
  localparam logic [7:0] OFS_MAIN_SZ   = 8'h24;
  localparam logic [7:0] OFS_SPARE_SZ  = 8'h28;
  localparam logic [7:0] OFS_CHUNK_CNT = 8'h30;
  localparam logic [7:0] OFS_DMA_CTRL  = 8'h40;
  localparam logic [7:0] OFS_MAIN_ADR  = 8'h44;
  localparam logic [7:0] OFS_SPARE_ADR = 8'h48;

  localparam logic [31:0] CFG_MASK  = 32'h0000_0079;
  localparam logic [31:0] HOST_MASK = 32'h0000_0035;
  localparam logic [31:0] CTRL_KEEP = 32'h6000_0002;
  localparam int unsigned CTRL_GO   = 31;
  localparam int unsigned CTRL_RD   = 1;

  typedef struct packed {
    logic [7:0] total;
    logic [7:0] rsv;
    logic [7:0] parity;
    logic [7:0] meta;
  } spare_fields_t;

  // Correctable bits per chunk; indices past the last clamp to the strongest.
  function automatic int unsigned corr_strength(input logic [3:0] kind);
    case (kind)
      4'd0:    return 4;
      4'd1:    return 8;
      4'd2:    return 40;
      default: return 48;
    endcase
  endfunction

  function automatic int unsigned spare_total(input logic [3:0] kind);
    return (kind < 4'd2) ? 32 : 96;
  endfunction

  function automatic int unsigned parity_bytes(input logic [3:0] kind,
                                               input int unsigned gf_bits);
    return (corr_strength(kind) * gf_bits + 7) / 8;
  endfunction

  function automatic spare_fields_t spare_layout(input logic [3:0] kind,
                                                 input int unsigned meta_b,
                                                 input int unsigned gf_bits);
    spare_fields_t f;
    int unsigned tot, par;
    tot      = spare_total(kind);
    par      = parity_bytes(kind, gf_bits);
    f.meta   = 8'(meta_b);
    f.parity = 8'(par);
    f.total  = 8'(tot);
    f.rsv    = 8'(tot - par - meta_b);
    return f;
  endfunction

endpackage

// File: rtl/ecc_spare_map.sv
module ecc_spare_map
  import ecc_regs_pkg::*;
#(
  parameter int unsigned META_BYTES = 4,
  parameter int unsigned GF_BITS    = 14
) (
  input  logic [3:0]    kind_i,
  output spare_fields_t fields_o
);

  assign fields_o = spare_layout(kind_i, META_BYTES, GF_BITS);

  // R7: the three sub-fields must add up to the total spare size
  always_comb begin
    p_spare_sum_r7: assert ((9'(fields_o.meta) + 9'(fields_o.parity) + 9'(fields_o.rsv))
                            == 9'(fields_o.total))
      else $error("spare layout fields do not sum to total");
  end

endmodule

// File: rtl/ecc_irq_ctrl.sv
module ecc_irq_ctrl #(
  parameter int unsigned N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] sts_en_i,
  input  logic [N-1:0] sig_en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o,
  output logic         irq_o
);

  logic [N-1:0] sts_q;
  logic [N-1:0] latch_evt;   // events that pass the status-enable gate
  logic [N-1:0] pending;     // recorded bits that pass the signal gate

  assign latch_evt = evt_i & sts_en_i;
  assign pending   = sts_q & sig_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= (sts_q & ~clr_i) | latch_evt;
  end

  assign sts_o = sts_q;
  assign irq_o = |pending;

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R3: a bit only appears after an enabled event
    p_set_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[i]) |-> $past(evt_i[i] && sts_en_i[i]))
      else $error("status bit %0d set without enabled event", i);
    // R4: a bit only disappears after a write-one-to-clear
    p_clear_needs_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts_q[i]) |-> $past(clr_i[i]))
      else $error("status bit %0d cleared without write of 1", i);
  end

endmodule

// File: rtl/ecc_dma_launch.sv
module ecc_dma_launch
  import ecc_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] ctrl_o,
  output logic        start_o
);

  logic [31:0] ctrl_q;
  logic        start_q;
  logic        go_req;

  assign go_req = wr_hit_i && wdata_i[CTRL_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= 1'b0;
    end else begin
      if (wr_hit_i) ctrl_q <= wdata_i & CTRL_KEEP;
      start_q <= go_req;
    end
  end

  assign ctrl_o  = ctrl_q;
  assign start_o = start_q;

  // R6: the launch pulse is a single cycle wide
  p_start_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q)
    else $error("start pulse longer than one cycle");
  // R6: the launch pulse always follows a go write
  p_start_after_go_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(go_req))
    else $error("start pulse without go write");

endmodule

// File: rtl/ecc_regfile.sv
module ecc_regfile
  import ecc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned STEP_BYTES = 1024,
  parameter int unsigned META_BYTES = 4,
  parameter int unsigned GF_BITS    = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  output logic [31:0]          rdata_o,
  input  logic [EVT_N-1:0]     evt_i,
  output logic                 irq_o,
  output logic                 engine_en_o,
  output logic [3:0]           ecc_type_o,
  output logic [5:0]           host_mode_o,
  output logic [CNT_W-1:0]     chunk_cnt_o,
  output logic [31:0]          slave_addr_o,
  output logic [31:0]          main_addr_o,
  output logic [31:0]          spare_addr_o,
  output logic                 start_o,
  output logic                 dir_read_o
);

  localparam logic [31:0] STEP_W = 32'(STEP_BYTES);

  logic [7:0]       ofs;
  logic             wr_cfg, wr_sts, wr_sts_en, wr_sig_en, wr_host;
  logic             wr_slave, wr_cnt, wr_ctrl, wr_madr, wr_sadr;
  logic [31:0]      cfg_q, host_q, slave_q, madr_q, sadr_q;
  logic [EVT_N-1:0] sts_en_q, sig_en_q, sts_w, clr_vec;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      ctrl_w, rd_mux, rdata_q;
  spare_fields_t    spare_w;

  assign ofs       = 8'(addr_i);
  assign wr_cfg    = wr_en_i && ofs == OFS_CFG;
  assign wr_sts    = wr_en_i && ofs == OFS_STS;
  assign wr_sts_en = wr_en_i && ofs == OFS_STS_EN;
  assign wr_sig_en = wr_en_i && ofs == OFS_SIG_EN;
  assign wr_host   = wr_en_i && ofs == OFS_HOST;
  assign wr_slave  = wr_en_i && ofs == OFS_SLAVE;
  assign wr_cnt    = wr_en_i && ofs == OFS_CHUNK_CNT;
  assign wr_ctrl   = wr_en_i && ofs == OFS_DMA_CTRL;
  assign wr_madr   = wr_en_i && ofs == OFS_MAIN_ADR;
  assign wr_sadr   = wr_en_i && ofs == OFS_SPARE_ADR;
  assign clr_vec   = wr_sts ? wdata_i[EVT_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      host_q   <= '0;
      slave_q  <= '0;
      madr_q   <= '0;
      sadr_q   <= '0;
      sts_en_q <= '0;
      sig_en_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_cfg)    cfg_q    <= wdata_i & CFG_MASK;
      if (wr_host)   host_q   <= wdata_i & HOST_MASK;
      if (wr_slave)  slave_q  <= wdata_i;
      if (wr_madr)   madr_q   <= wdata_i;
      if (wr_sadr)   sadr_q   <= wdata_i;
      if (wr_sts_en) sts_en_q <= wdata_i[EVT_N-1:0];
      if (wr_sig_en) sig_en_q <= wdata_i[EVT_N-1:0];
      if (wr_cnt)    cnt_q    <= wdata_i[CNT_W-1:0];
    end
  end

  ecc_irq_ctrl #(.N(EVT_N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .sts_en_i (sts_en_q),
    .sig_en_i (sig_en_q),
    .clr_i    (clr_vec),
    .sts_o    (sts_w),
    .irq_o    (irq_o)
  );

  ecc_dma_launch u_launch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit_i (wr_ctrl),
    .wdata_i  (wdata_i),
    .ctrl_o   (ctrl_w),
    .start_o  (start_o)
  );

  ecc_spare_map #(.META_BYTES(META_BYTES), .GF_BITS(GF_BITS)) u_spare (
    .kind_i   (cfg_q[6:3]),
    .fields_o (spare_w)
  );

  always_comb begin
    case (ofs)
      OFS_CFG:       rd_mux = cfg_q;
      OFS_STS:       rd_mux = 32'(sts_w);
      OFS_STS_EN:    rd_mux = 32'(sts_en_q);
      OFS_SIG_EN:    rd_mux = 32'(sig_en_q);
      OFS_HOST:      rd_mux = host_q;
      OFS_SLAVE:     rd_mux = slave_q;
      OFS_CHUNK_SZ:  rd_mux = STEP_W + 32'(spare_w.total);
      OFS_MAIN_SZ:   rd_mux = STEP_W;
      OFS_SPARE_SZ:  rd_mux = spare_w;
      OFS_CHUNK_CNT: rd_mux = 32'(cnt_q);
      OFS_DMA_CTRL:  rd_mux = ctrl_w;
      OFS_MAIN_ADR:  rd_mux = madr_q;
      OFS_SPARE_ADR: rd_mux = sadr_q;
      default:       rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o      = rdata_q;
  assign engine_en_o  = cfg_q[0];
  assign ecc_type_o   = cfg_q[6:3];
  assign host_mode_o  = host_q[5:0];
  assign chunk_cnt_o  = cnt_q;
  assign slave_addr_o = slave_q;
  assign main_addr_o  = madr_q;
  assign spare_addr_o = sadr_q;
  assign dir_read_o   = ctrl_w[CTRL_RD];

  // R6: the go bit is never visible on a read of DMA control
  p_go_reads_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en_i && ofs == OFS_DMA_CTRL) |-> !rdata_o[CTRL_GO])
    else $error("go bit read back as 1");

endmodule

// File: tb/ecc_regfile_bench.sv
module ecc_regfile_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] rdata;
  logic [5:0]  evt = '0;
  logic        irq, en, start, dir_rd;
  logic [3:0]  etype;
  logic [5:0]  hmode;
  logic [7:0]  ccnt;
  logic [31:0] slv, madr, sadr;

  int n_checks = 0;
  int n_fail   = 0;
  logic        rd_seen = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  ecc_regfile u_ecc_regfile (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata), .evt_i(evt),
    .irq_o(irq), .engine_en_o(en), .ecc_type_o(etype), .host_mode_o(hmode),
    .chunk_cnt_o(ccnt), .slave_addr_o(slv), .main_addr_o(madr),
    .spare_addr_o(sadr), .start_o(start), .dir_read_o(dir_rd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares every returned read against the queue
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R2 unexpected read", rdata, 32'hDEAD_BEEF);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [5:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
  endtask

  // Expected spare layout, derived from R7 in a different form
  function automatic logic [31:0] exp_spare(input int kind);
    int s, tot, par, meta;
    s    = (kind == 0) ? 4 : (kind == 1) ? 8 : (kind == 2) ? 40 : 48;
    tot  = (kind <= 1) ? 32 : 96;
    par  = (s * 7 + 3) / 4;
    meta = 4;
    return {8'(tot), 8'(tot - meta - par), 8'(par), 8'(meta)};
  endfunction

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 start", 32'(start), 0);
    rd_expect(8'h00, 0, "R1 cfg");
    rd_expect(8'h04, 0, "R1 sts");
    rd_expect(8'h40, 0, "R1 ctrl");

    // R2 masked read-back, R9 outputs
    wr(8'h00, 32'hFFFF_FFFF);
    rd_expect(8'h00, 32'h79, "R2 cfg mask");
    check("R9 engine_en", 32'(en), 1);
    check("R9 ecc_type", 32'(etype), 32'hF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd_expect(8'h10, 32'h35, "R2 host mask");
    check("R9 host_mode", 32'(hmode), 32'h35);
    wr(8'h14, 32'hA5A5_1234);
    rd_expect(8'h14, 32'hA5A5_1234, "R2 slave");
    wr(8'h44, 32'h1357_9BDF);
    wr(8'h48, 32'h8000_0F00);
    rd_expect(8'h44, 32'h1357_9BDF, "R2 main addr");
    rd_expect(8'h48, 32'h8000_0F00, "R2 spare addr");
    check("R9 main addr", madr, 32'h1357_9BDF);
    check("R9 spare addr", sadr, 32'h8000_0F00);
    check("R9 slave addr", slv, 32'hA5A5_1234);
    wr(8'h30, 32'h0000_01FF);
    rd_expect(8'h30, 32'hFF, "R2 chunk count");
    check("R9 chunk count", 32'(ccnt), 32'hFF);

    // R7 spare layout per type, R8 size registers
    rd_expect(8'h28, exp_spare(15), "R7 type 15 clamp");
    for (int k = 0; k < 4; k++) begin
      wr(8'h00, 32'(k) << 3);
      rd_expect(8'h28, exp_spare(k), "R7 spare layout");
      rd_expect(8'h20, 32'd1024 + ((k <= 1) ? 32 : 96), "R8 chunk size");
    end
    rd_expect(8'h28, 32'h6008_5404, "R7 type 3 literal");
    wr(8'h28, 32'h0);
    rd_expect(8'h28, 32'h6008_5404, "R7 write ignored");
    rd_expect(8'h24, 32'd1024, "R8 main size");

    // R3 status enable gate
    pulse_evt(6'h3F);
    rd_expect(8'h04, 0, "R3 disabled events dropped");
    wr(8'h08, 32'h15);
    pulse_evt(6'h3F);
    rd_expect(8'h04, 32'h15, "R3 enabled events latched");

    // R5 interrupt signal gate
    check("R5 irq no signal enable", 32'(irq), 0);
    wr(8'h0C, 32'h04);
    check("R5 irq raised", 32'(irq), 1);
    wr(8'h0C, 32'h02);
    check("R5 irq masked", 32'(irq), 0);

    // R4 write-one-to-clear
    wr(8'h04, 32'h01);
    rd_expect(8'h04, 32'h14, "R4 clear bit0");
    wr(8'h04, 32'h00);
    rd_expect(8'h04, 32'h14, "R4 zero write no effect");
    wr(8'h08, 32'h3F);
    @(negedge clk); addr = 8'h04; wdata = 32'h10; wr_en = 1'b1; evt = 6'h10;
    @(negedge clk); wr_en = 1'b0; evt = '0;
    rd_expect(8'h04, 32'h14, "R4 event beats clear");
    wr(8'h04, 32'h14);
    rd_expect(8'h04, 0, "R4 full clear");
    wr(8'h0C, 32'h3F);
    check("R5 irq low when empty", 32'(irq), 0);

    // R6 start pulse and DMA control
    wr(8'h40, 32'hE000_0002);
    check("R6 start pulse", 32'(start), 1);
    check("R6 dir read", 32'(dir_rd), 1);
    @(negedge clk);
    check("R6 start single cycle", 32'(start), 0);
    rd_expect(8'h40, 32'h6000_0002, "R6 ctrl readback");
    wr(8'h40, 32'h8000_0000);
    check("R6 second start", 32'(start), 1);
    check("R6 dir write", 32'(dir_rd), 0);
    wr(8'h40, 32'h0000_0002);
    check("R6 no start without go", 32'(start), 0);

    // R8 unmapped offsets
    wr(8'h18, 32'hFFFF_FFFF);
    rd_expect(8'h18, 0, "R8 unmapped 0x18");
    wr(8'h3C, 32'h1234_5678);
    rd_expect(8'h3C, 0, "R8 unmapped 0x3C");
    rd_expect(8'h14, 32'hA5A5_1234, "R8 unmapped write left slave intact");

    repeat (3) @(negedge clk);
    check("R2 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end

endmodule